// File: doc/BRIEF.md
# ADC Sequencing and Register Control Unit

This block is the digital front of a single multiplexed analog-to-digital converter. Software reaches it over a small byte-wide register bus. The registers hold the reference and channel select codes, an enable, a start bit, an automatic-start mode with a source selector, a completion flag with its interrupt enable, and a clock divider code. The analog multiplexer, the reference circuitry and the converter itself are outside the block. The block only drives the select codes to them and runs the handshake with the conversion engine.

The system clock is divided down to a converter clock-enable strobe. Conversions are requested in one of three ways: by software, by repeating automatically after each completion, or by a rising edge on a selected trigger input. A request is handed to the engine as a one-cycle start pulse on the next strobe. While a request is waiting or a conversion is running, further trigger events are dropped. When the engine reports completion, the block stores the 10-bit result, sets the completion flag and raises the interrupt request if it is enabled. The result is read as two bytes, low byte first. Reading the low byte freezes the upper bits, so a conversion that finishes between the two reads cannot split the value.

Top module: `adc_ctrl`

## Requirements
- R1: While enabled, `conv_clk_en_o` pulses once every D cycles, where D = 2^max(code,1) for the 3-bit divider code in control bits [2:0]. Codes 0 and 1 both give 2, and code 7 gives 128. When the block is disabled the strobe stays low and the divider restarts from zero.
- R2: Address 0 holds the reference code in bits [7:6] and the channel code in bits [3:0], and bits [5:4] read 0. The fields drive `ref_sel_o` and `chan_o` directly. Reference codes: 00 external pin, 01 analog supply, 10 reserved, 11 internal 1.1 V.
- R3: Writing address 1 with bit 7 (enable) and bit 6 (start) both 1 while idle creates a pending request. `conv_start_o` pulses for one cycle on the first divider strobe after that. Bit 6 reads 1 from the request until completion, and a request and a running conversion never coexist.
- R4: With auto mode (control bit 5) set and source code 0, every accepted completion immediately re-arms a new request, so a single start keeps conversions running.
- R5: With auto mode set and source code n ≠ 0 (address 2 bits [2:0]), a rising edge on `trig_i[n]` creates a request. The edge is detected after a two-stage synchronizer. Code 4 is the timer-overflow input. Edges on other inputs, and edges arriving while a request is pending or a conversion is running, are ignored.
- R6: `conv_done_i` while a conversion is running sets the completion flag (control bit 4) and stores `conv_result_i`. A completion at any other time changes neither the flag nor the result.
- R7: Writing address 1 with bit 4 set clears the flag, and so does `irq_ack_i`. A completion in the same cycle wins over the clear.
- R8: `irq_o` is high exactly when the flag and the interrupt enable (control bit 3) are both set.
- R9: Address 3 reads result bits [7:0]. Reading it with `reg_rd_i` copies result bits [9:8] into address 4 bits [1:0], whose other bits read 0.
- R10: Writing control with bit 7 clear drops any pending request and any running conversion. A completion that arrives afterwards is ignored, and the stored result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effect on address 3) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current address, combinational |
| trig_i | input | 8 | Asynchronous trigger sources, index = source code |
| irq_ack_i | input | 1 | Interrupt serviced, clears the flag |
| irq_o | output | 1 | Interrupt request |
| ref_sel_o | output | 2 | Reference select code |
| chan_o | output | 4 | Channel select code |
| conv_clk_en_o | output | 1 | Converter clock-enable strobe |
| conv_start_o | output | 1 | One-cycle conversion start to the engine |
| conv_done_i | input | 1 | Engine completion pulse |
| conv_result_i | input | 10 | Engine result, valid with `conv_done_i` |

## Verification
Register writes, flag changes and the stored result take effect on the edge that samples the strobe and are visible from the next cycle. `irq_o`, the read data and the start pulse are combinational from that state. A trigger edge becomes a pending request on the third clock edge after it arrives, and the start follows on the next divider strobe. The bench's behavioural model steps through the same edges and is compared with every output once per cycle, on the falling edge. Directed checks then confirm divider counts, flag and interrupt behaviour, protection of the split read, and the ignored events.

// File: rtl/adc_ctrl_pkg.sv
`timescale 1ns/1ps
package adc_ctrl_pkg;
  localparam int DATA_W   = 8;
  localparam int RES_W    = 10;
  localparam int HI_W     = RES_W - DATA_W;
  localparam int CHAN_W   = 4;
  localparam int REF_W    = 2;
  localparam int SRC_W    = 3;
  localparam int NUM_TRIG = 1 << SRC_W;
  localparam int PRESC_W  = 3;
  localparam int MAX_DIV  = 1 << ((1 << PRESC_W) - 1);
  localparam int CNT_W    = $clog2(MAX_DIV);
  localparam int ADDR_W   = 3;
  localparam int SYNC_N   = 2;

  localparam logic [ADDR_W-1:0] A_SEL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_TRIG   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RES_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_RES_HI = 3'd4;

  // control register bit positions
  localparam int B_EN   = 7;
  localparam int B_GO   = 6;
  localparam int B_AUTO = 5;
  localparam int B_FLAG = 4;
  localparam int B_IE   = 3;
  localparam int REF_LSB = DATA_W - REF_W;
endpackage

// File: rtl/adc_prescaler.sv
`timescale 1ns/1ps
module adc_prescaler #(
  parameter int PRESC_W = 3,
  parameter int CNT_W   = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PRESC_W-1:0] code_i,
  output logic               tick_o
);
  logic [CNT_W-1:0] cnt_q, last;
  int               sh;

  always_comb begin
    sh   = (code_i == '0) ? 1 : int'(code_i);
    last = CNT_W'((32'd1 << sh) - 32'd1);
  end

  assign tick_o = en_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  // R1
  presc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  // R1
  presc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == '0);
endmodule

// File: rtl/adc_trig_detect.sv
`timescale 1ns/1ps
module adc_trig_detect #(
  parameter int NUM_TRIG = 8,
  parameter int SRC_W    = 3,
  parameter int SYNC_N   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [SRC_W-1:0]    src_i,
  output logic                evt_o
);
  logic [SYNC_N-1:0][NUM_TRIG-1:0] sync_q;
  logic [NUM_TRIG-1:0]             prev_q, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], trig_i};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign rise  = sync_q[SYNC_N-1] & ~prev_q;
  assign evt_o = rise[src_i];

  // R5
  edge_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> prev_q[$past(src_i)]);
endmodule

// File: rtl/adc_result_buf.sv
`timescale 1ns/1ps
module adc_result_buf #(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [RES_W-1:0]        res_i,
  input  logic                    rd_lo_i,
  output logic [RES_W-1:0]        res_o,
  output logic [RES_W-DATA_W-1:0] hi_o
);
  logic [RES_W-1:0]        res_q;
  logic [RES_W-DATA_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      hi_q  <= '0;
    end else begin
      if (load_i)  res_q <= res_i;
      if (rd_lo_i) hi_q  <= res_q[RES_W-1:DATA_W];
    end
  end

  assign res_o = res_q;
  assign hi_o  = hi_q;

  // R9
  hi_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> hi_q == $past(res_q[RES_W-1:DATA_W]));
  // R6
  res_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> res_q == $past(res_i));
  // R10
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(res_q));
endmodule

// File: rtl/adc_ctrl.sv
`timescale 1ns/1ps
module adc_ctrl
  import adc_ctrl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic                irq_ack_i,
  output logic                irq_o,
  output logic [REF_W-1:0]    ref_sel_o,
  output logic [CHAN_W-1:0]   chan_o,
  output logic                conv_clk_en_o,
  output logic                conv_start_o,
  input  logic                conv_done_i,
  input  logic [RES_W-1:0]    conv_result_i
);
  logic [REF_W-1:0]   ref_q;
  logic [CHAN_W-1:0]  chan_q;
  logic [PRESC_W-1:0] presc_q;
  logic [SRC_W-1:0]   src_q;
  logic en_q, auto_q, ie_q, flag_q, pend_q, busy_q;
  logic pend_d, busy_d;
  logic wr_sel, wr_ctrl, wr_trig, rd_lo;
  logic tick, evt, issue, done_ok, free_run, idle, en_next, sw_go, trig_go;
  logic [RES_W-1:0] res;
  logic [HI_W-1:0]  res_hi;

  assign wr_sel  = reg_wr_i && (reg_addr_i == A_SEL);
  assign wr_ctrl = reg_wr_i && (reg_addr_i == A_CTRL);
  assign wr_trig = reg_wr_i && (reg_addr_i == A_TRIG);
  assign rd_lo   = reg_rd_i && (reg_addr_i == A_RES_LO);

  adc_prescaler #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_presc (
    .clk_i, .rst_ni, .en_i(en_q), .code_i(presc_q), .tick_o(tick)
  );

  adc_trig_detect #(.NUM_TRIG(NUM_TRIG), .SRC_W(SRC_W), .SYNC_N(SYNC_N)) u_trig (
    .clk_i, .rst_ni, .trig_i, .src_i(src_q), .evt_o(evt)
  );

  adc_result_buf #(.RES_W(RES_W), .DATA_W(DATA_W)) u_res (
    .clk_i, .rst_ni, .load_i(done_ok), .res_i(conv_result_i),
    .rd_lo_i(rd_lo), .res_o(res), .hi_o(res_hi)
  );

  assign issue    = pend_q && tick;
  assign done_ok  = en_q && busy_q && conv_done_i;
  assign free_run = auto_q && (src_q == '0);
  assign idle     = !pend_q && !busy_q;
  assign en_next  = wr_ctrl ? reg_wdata_i[B_EN] : en_q;
  assign sw_go    = wr_ctrl && reg_wdata_i[B_EN] && reg_wdata_i[B_GO];
  assign trig_go  = en_q && auto_q && (src_q != '0) && evt;

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    if (issue) begin
      pend_d = 1'b0;
      busy_d = 1'b1;
    end
    if (done_ok) begin
      busy_d = 1'b0;
      if (free_run) pend_d = 1'b1;
    end
    if (idle && (sw_go || trig_go)) pend_d = 1'b1;
    if (!en_next) begin
      pend_d = 1'b0;
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= '0;
      chan_q  <= '0;
      presc_q <= '0;
      src_q   <= '0;
      en_q    <= 1'b0;
      auto_q  <= 1'b0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      if (wr_sel) begin
        ref_q  <= reg_wdata_i[DATA_W-1:REF_LSB];
        chan_q <= reg_wdata_i[CHAN_W-1:0];
      end
      if (wr_ctrl) begin
        en_q    <= reg_wdata_i[B_EN];
        auto_q  <= reg_wdata_i[B_AUTO];
        ie_q    <= reg_wdata_i[B_IE];
        presc_q <= reg_wdata_i[PRESC_W-1:0];
      end
      if (wr_trig) src_q <= reg_wdata_i[SRC_W-1:0];
      // completion wins over a clear in the same cycle
      if (done_ok) flag_q <= 1'b1;
      else if ((wr_ctrl && reg_wdata_i[B_FLAG]) || irq_ack_i) flag_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_SEL: begin
        reg_rdata_o[DATA_W-1:REF_LSB] = ref_q;
        reg_rdata_o[CHAN_W-1:0]       = chan_q;
      end
      A_CTRL: begin
        reg_rdata_o[B_EN]          = en_q;
        reg_rdata_o[B_GO]          = pend_q || busy_q;
        reg_rdata_o[B_AUTO]        = auto_q;
        reg_rdata_o[B_FLAG]        = flag_q;
        reg_rdata_o[B_IE]          = ie_q;
        reg_rdata_o[PRESC_W-1:0]   = presc_q;
      end
      A_TRIG:   reg_rdata_o[SRC_W-1:0] = src_q;
      A_RES_LO: reg_rdata_o = res[DATA_W-1:0];
      A_RES_HI: reg_rdata_o[HI_W-1:0] = res_hi;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o         = flag_q && ie_q;
  assign ref_sel_o     = ref_q;
  assign chan_o        = chan_q;
  assign conv_clk_en_o = tick;
  assign conv_start_o  = issue;

  // R3
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !pend_q);
  // R3
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_q && busy_q));
  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && busy_q && conv_done_i) |=> flag_q);
  // R5
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !conv_done_i) |=> !pend_q);
  // R10
  disable_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == A_CTRL && !reg_wdata_i[B_EN])
      |=> (!pend_q && !busy_q && !conv_clk_en_o));
  // R7
  flag_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> ($past(irq_ack_i) || $past(reg_wr_i)));
endmodule

// File: tb/adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] trig = '0;
  logic       irq_ack = 1'b0;
  logic       irq;
  logic [1:0] ref_sel;
  logic [3:0] chan;
  logic       clk_en, start;
  logic       conv_done = 1'b0;
  logic [9:0] conv_result = '0;

  int n_vec = 0, n_bad = 0;
  bit fin = 1'b0;

  always #2 clk = ~clk;

  adc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .trig_i(trig), .irq_ack_i(irq_ack), .irq_o(irq), .ref_sel_o(ref_sel),
    .chan_o(chan), .conv_clk_en_o(clk_en), .conv_start_o(start),
    .conv_done_i(conv_done), .conv_result_i(conv_result)
  );

  // ---------------- behavioural reference ----------------
  logic [1:0] m_ref; logic [3:0] m_chan; logic [2:0] m_presc, m_src;
  logic m_en, m_auto, m_ie, m_flag, m_pend, m_busy;
  logic [9:0] m_res; logic [1:0] m_hi;
  int   m_cnt;
  logic [7:0] m_t1, m_t2, m_t3;   // trigger history, newest first

  function automatic int lim(input logic [2:0] c);
    return (1 << ((c == 0) ? 1 : int'(c))) - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ref = 0; m_chan = 0; m_presc = 0; m_src = 0;
      m_en = 0; m_auto = 0; m_ie = 0; m_flag = 0; m_pend = 0; m_busy = 0;
      m_res = 0; m_hi = 0; m_cnt = 0; m_t1 = 0; m_t2 = 0; m_t3 = 0;
    end else begin
      logic tk, iss, dn, ev, fr, idl, wc, en_n, n_pend, n_busy, n_flag;
      tk  = m_en && (m_cnt >= lim(m_presc));
      iss = m_pend && tk;
      dn  = m_en && m_busy && conv_done;
      ev  = m_t2[m_src] && !m_t3[m_src];
      fr  = m_auto && (m_src == 0);
      idl = !m_pend && !m_busy;
      wc  = reg_wr && (reg_addr == 3'd1);
      en_n = wc ? reg_wdata[7] : m_en;
      n_pend = m_pend; n_busy = m_busy; n_flag = m_flag;
      if (iss) begin n_pend = 0; n_busy = 1; end
      if (dn) begin n_busy = 0; if (fr) n_pend = 1; end
      if (idl && ((wc && reg_wdata[7] && reg_wdata[6]) ||
                  (m_en && m_auto && m_src != 0 && ev))) n_pend = 1;
      if (!en_n) begin n_pend = 0; n_busy = 0; end
      if (dn) n_flag = 1;
      else if ((wc && reg_wdata[4]) || irq_ack) n_flag = 0;
      if (reg_rd && reg_addr == 3'd3) m_hi = m_res[9:8];
      if (dn) m_res = conv_result;
      m_cnt = !m_en ? 0 : ((m_cnt >= lim(m_presc)) ? 0 : m_cnt + 1);
      m_t3 = m_t2; m_t2 = m_t1; m_t1 = trig;
      if (reg_wr && reg_addr == 3'd0) begin m_ref = reg_wdata[7:6]; m_chan = reg_wdata[3:0]; end
      if (wc) begin
        m_en = reg_wdata[7]; m_auto = reg_wdata[5]; m_ie = reg_wdata[3]; m_presc = reg_wdata[2:0];
      end
      if (reg_wr && reg_addr == 3'd2) m_src = reg_wdata[2:0];
      m_pend = n_pend; m_busy = n_busy; m_flag = n_flag;
    end
  end

  function automatic logic [7:0] exp_rd();
    case (reg_addr)
      3'd0: return {m_ref, 2'b00, m_chan};
      3'd1: return {m_en, m_pend | m_busy, m_auto, m_flag, m_ie, m_presc};
      3'd2: return {5'b0, m_src};
      3'd3: return m_res[7:0];
      3'd4: return {6'b0, m_hi};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_req();
    case (reg_addr)
      3'd0: return "R2";
      3'd1: return "R7";
      3'd2: return "R5";
      default: return "R9";
    endcase
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      logic tk_e;
      tk_e = m_en && (m_cnt >= lim(m_presc));
      n_vec++;
      if (clk_en !== tk_e) begin n_bad++; $display("FAIL R1 clk_en: actual %0b expected %0b", clk_en, tk_e); end
      if (start !== (m_pend && tk_e)) begin n_bad++; $display("FAIL R3 start: actual %0b expected %0b", start, m_pend && tk_e); end
      if (irq !== (m_flag && m_ie)) begin n_bad++; $display("FAIL R8 irq: actual %0b expected %0b", irq, m_flag && m_ie); end
      if (ref_sel !== m_ref || chan !== m_chan) begin n_bad++; $display("FAIL R2 sel: actual %0h/%0h expected %0h/%0h", ref_sel, chan, m_ref, m_chan); end
      if (reg_rdata !== exp_rd()) begin n_bad++; $display("FAIL %s rdata@%0d: actual %0h expected %0h", rd_req(), reg_addr, reg_rdata, exp_rd()); end
    end
  end

  // ---------------- conversion engine stand-in ----------------
  int eng_len = 6, eng_cnt = 0, stray_ev = 0, stray_seen = 0, n_starts = 0;
  logic [9:0] res_seq = 10'h2A5, last_res = '0;

  always @(negedge clk) if (start) n_starts++;

  initial begin
    forever begin
      logic s;
      @(negedge clk);
      s = start;
      #1;
      conv_done = 1'b0;
      if (stray_ev != stray_seen) begin
        stray_seen = stray_ev; conv_done = 1'b1; conv_result = 10'h3FF;
      end else if (s) eng_cnt = eng_len;
      else if (eng_cnt > 0) begin
        eng_cnt--;
        if (eng_cnt == 0) begin
          conv_done = 1'b1; conv_result = res_seq; last_res = res_seq;
          res_seq = 10'((int'(res_seq) * 37 + 11) % 1024);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); #1; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); #1; reg_addr = a; reg_rd = 1'b1; #0.5; d = reg_rdata;
    @(negedge clk); #1; reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig(input int idx);
    @(negedge clk); #1; trig[idx] = 1'b1;
    repeat (2) @(negedge clk); #1; trig[idx] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic measure(input logic [2:0] code, input int ncyc, input int exp);
    int ticks = 0;
    wr(3'd1, 8'h00);
    wr(3'd1, {5'b10000, code});
    repeat (ncyc) begin @(negedge clk); if (clk_en) ticks++; end
    chk($sformatf("R1 divider code %0d", code), ticks, exp);
  endtask

  initial begin
    logic [7:0] v;
    logic [9:0] a_res;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset strobe", clk_en, 0);
    chk("R8 reset irq", irq, 0);
    rd(3'd1, v); chk("R3 reset ctrl", v, 8'h00);
    rd(3'd0, v); chk("R2 reset sel", v, 8'h00);

    // R2 select fields
    wr(3'd0, 8'hC5);
    chk("R2 ref out", ref_sel, 3); chk("R2 chan out", chan, 5);
    wr(3'd0, 8'hFF);
    rd(3'd0, v); chk("R2 readback pad", v, 8'hCF);
    wr(3'd0, 8'h41);

    // R1 divider ratios
    measure(3'd0, 20, 10);
    measure(3'd1, 20, 10);
    measure(3'd3, 64, 8);
    measure(3'd7, 256, 2);
    wr(3'd1, 8'h00);
    idle(4);
    chk("R10 strobe off", clk_en, 0);

    // R3 software start, R6 completion
    n_starts = 0; eng_len = 6;
    wr(3'd1, 8'hC2);
    rd(3'd1, v); chk("R3 start bit reads busy", v[6], 1);
    idle(30);
    rd(3'd1, v); chk("R3 R6 done ctrl", v, 8'h92);
    chk("R3 one start", n_starts, 1);

    // R9 split read with protection
    a_res = last_res;
    rd(3'd3, v); chk("R9 low byte", v, a_res[7:0]);
    rd(3'd4, v); chk("R9 high bits", v, {6'b0, a_res[9:8]});
    rd(3'd3, v);
    wr(3'd1, 8'h92);
    wr(3'd1, 8'hC2);
    idle(30);
    rd(3'd4, v); chk("R9 high frozen", v, {6'b0, a_res[9:8]});
    rd(3'd3, v); chk("R9 new low", v, last_res[7:0]);
    rd(3'd4, v); chk("R9 new high", v, {6'b0, last_res[9:8]});

    // R8 / R7 interrupt and flag clearing
    wr(3'd1, 8'h8A); chk("R8 irq on", irq, 1);
    wr(3'd1, 8'h82); chk("R8 irq masked", irq, 0);
    wr(3'd1, 8'h8A); chk("R8 irq again", irq, 1);
    @(negedge clk); #1 irq_ack = 1'b1;
    @(negedge clk); #1 irq_ack = 1'b0;
    chk("R7 ack clears", irq, 0);
    wr(3'd1, 8'hCA);
    idle(30);
    chk("R8 irq after done", irq, 1);
    wr(3'd1, 8'h9A);
    rd(3'd1, v); chk("R7 w1c clears", v, 8'h8A);
    wr(3'd1, 8'h82);

    // R4 free running
    n_starts = 0;
    wr(3'd2, 8'h00);
    wr(3'd1, 8'hE2);
    idle(150);
    chk("R4 repeats", int'(n_starts >= 3), 1);
    wr(3'd1, 8'h82);
    idle(60);
    wr(3'd1, 8'h92);

    // R5 triggered starts
    n_starts = 0; eng_len = 20;
    wr(3'd2, 8'h04);
    wr(3'd1, 8'hA2);
    pulse_trig(4);
    idle(3);
    pulse_trig(4);
    pulse_trig(4);
    idle(40);
    chk("R5 busy events ignored", n_starts, 1);
    pulse_trig(3);
    idle(20);
    chk("R5 other source ignored", n_starts, 1);
    pulse_trig(4);
    idle(40);
    chk("R5 next edge starts", n_starts, 2);
    wr(3'd1, 8'h92);

    // R6 completion while idle is ignored
    a_res = last_res;
    stray_ev++;
    idle(4);
    rd(3'd1, v); chk("R6 stray done flag", v, 8'h82);
    rd(3'd3, v); chk("R6 stray done result", v, a_res[7:0]);

    // R10 disable mid-conversion
    wr(3'd1, 8'hC2);
    idle(8);
    wr(3'd1, 8'h02);
    rd(3'd1, v); chk("R10 dropped", v, 8'h02);
    idle(30);
    rd(3'd1, v); chk("R10 late done ignored", v, 8'h02);
    rd(3'd3, v); chk("R10 result kept", v, a_res[7:0]);
    chk("R10 strobe low", clk_en, 0);

    if (!fin) begin
      fin = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!fin) begin
      fin = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule